// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. Four pins drive it: a test clock, a mode select, serial data in and an active-low asynchronous reset. One serial data output comes back, together with an output enable. A sixteen-state controller walks the standard scan sequence under control of the mode select. A 4-bit instruction register chooses which data register sits between serial in and serial out. Three paths can be chosen: a one-stage bypass flop, a 32-bit identification register, and the serial output of an external boundary-scan chain.

The boundary-scan cells sit outside this block. To drive them, the controller exports its data-register capture, shift and update strobes and a one-hot decode of the active instruction. The cells' serial output returns on a dedicated input. Mode select and serial input are sampled on the rising test-clock edge. The serial output is launched on the falling edge.

Top module: `scan_tap`

## Requirements
- R1: The controller follows the standard sixteen-state scan sequence. Every transition is taken on the rising edge of `tck` and depends only on `tms`. Asynchronous assertion of `trstN` forces the reset state.
- R2: Five consecutive rising `tck` edges with `tms` high reach the reset state from any state. In the reset state the active instruction becomes IDCODE.
- R3: `tdoEn` is high only while the controller is in Shift-DR or Shift-IR. It changes on the falling edge of `tck`.
- R4: In Capture-IR the instruction shift register loads binary 0001. This value is shifted out LSB first on `tdo` during Shift-IR.
- R5: Under IDCODE, Capture-DR loads a 32-bit constant: version in bits 31:28, part number in bits 27:12, manufacturer in bits 11:1, and bit 0 fixed at 1. Shift-DR shifts it out LSB first.
- R6: Under BYPASS, a single flop sits between `tdi` and `tdo`. It captures 0 in Capture-DR, so the bits appear on `tdo` one shift later.
- R7: Instruction codes decode as follows: 0000 is EXTEST, 0001 is SAMPLE/PRELOAD, 0010 is IDCODE, and 1111 and every other code select bypass. Exactly one select output is high at a time.
- R8: Under EXTEST and SAMPLE/PRELOAD, the data path in Shift-DR routes `bsrSerialIn`, as seen on the falling edge, to `tdo`.
- R9: A newly shifted instruction becomes active only on the falling `tck` edge in Update-IR. Before that, the previous decode stays on the select outputs.
- R10: `dataCapture`, `dataShift` and `dataUpdate` are high exactly in Capture-DR, Shift-DR and Update-DR respectively.
- R11: `tdo` holds its value across the rising `tck` edge and changes only on the falling edge.
- R12: Asserting `trstN` low takes effect at once, without a clock edge: `tdoEn` drops and IDCODE is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bsrSerialIn | input | 1 | Serial output of the external boundary-scan chain |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdoEn | output | 1 | Output enable for `tdo` |
| dataCapture | output | 1 | Controller is in Capture-DR |
| dataShift | output | 1 | Controller is in Shift-DR |
| dataUpdate | output | 1 | Controller is in Update-DR |
| selExtest | output | 1 | EXTEST is active |
| selSamplePreload | output | 1 | SAMPLE/PRELOAD is active |
| selIdcode | output | 1 | IDCODE is active |
| selBypass | output | 1 | Bypass path is active |

## Verification
The bench sweeps all sixteen controller states. In each one it checks the enable and the strobes. It then applies five high `tms` clocks and confirms that IDCODE comes back. A controller with a missing or wrong arc would leave bypass selected, or would enable the output in a non-shift state. All sixteen instruction codes are loaded and scanned through the data path. A decode that sent an unused code anywhere but bypass, or confused the bypass delay with the chain path, would produce wrong serial streams. Separate cases cover the following:
- Falling-edge launch of `tdo`: a rising-edge launch would show the new bit too early.
- Instruction activation held off until Update-IR: an early update would switch the selects in Exit1-IR.
- Reset asserted in the middle of a shift: a synchronous reset would leave the output enabled.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] INS_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] INS_SAMPLE = 4'b0001;
  localparam logic [IR_W-1:0] INS_IDCODE = 4'b0010;
  localparam logic [IR_W-1:0] INS_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 4'b0001;

  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAUSE_DR, TAP_EX2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAUSE_IR, TAP_EX2_IR, TAP_UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {SEL_EXTEST, SEL_SAMPLE, SEL_IDCODE, SEL_BYPASS} instrSel_e;

  typedef struct packed {
    logic inReset;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
  } tapStrobe_t;

endpackage

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapState_e  stateQ,
  output tapStrobe_t strobe
);

  tapState_e stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      TAP_RESET:    stateD = tms ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:     stateD = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR:   stateD = tms ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR:   stateD = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:    stateD = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR:   stateD = tms ? TAP_UPD_DR : TAP_PAUSE_DR;
      TAP_PAUSE_DR: stateD = tms ? TAP_EX2_DR : TAP_PAUSE_DR;
      TAP_EX2_DR:   stateD = tms ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR:   stateD = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR:   stateD = tms ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR:   stateD = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:    stateD = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR:   stateD = tms ? TAP_UPD_IR : TAP_PAUSE_IR;
      TAP_PAUSE_IR: stateD = tms ? TAP_EX2_IR : TAP_PAUSE_IR;
      TAP_EX2_IR:   stateD = tms ? TAP_UPD_IR : TAP_SH_IR;
      TAP_UPD_IR:   stateD = tms ? TAP_SEL_DR : TAP_IDLE;
      default:      stateD = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) stateQ <= TAP_RESET;
    else        stateQ <= stateD;
  end

  always_comb begin
    strobe.inReset   = (stateQ == TAP_RESET);
    strobe.captureDr = (stateQ == TAP_CAP_DR);
    strobe.shiftDr   = (stateQ == TAP_SH_DR);
    strobe.updateDr  = (stateQ == TAP_UPD_DR);
    strobe.captureIr = (stateQ == TAP_CAP_IR);
    strobe.shiftIr   = (stateQ == TAP_SH_IR);
    strobe.updateIr  = (stateQ == TAP_UPD_IR);
  end

endmodule

// File: rtl/scan_tap_dp.sv
module scan_tap_dp
  import scan_tap_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1
)
(
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  input  logic            bsrSerialIn,
  input  tapStrobe_t      strobe,
  output logic            tdo,
  output logic            tdoEn,
  output instrSel_e       instrSel,
  output logic [IR_W-1:0] irActive,
  output logic [IR_W-1:0] irShift
);

  logic [IR_W-1:0] irShiftQ;
  logic [IR_W-1:0] irActiveQ;
  logic [ID_W-1:0] idShiftQ;
  logic            bypassQ;
  logic            drOut;

  // instruction shift stage: capture pattern, then shift toward LSB
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                irShiftQ <= IR_CAPTURE_VAL;
    else if (strobe.captureIr) irShiftQ <= IR_CAPTURE_VAL;
    else if (strobe.shiftIr)   irShiftQ <= {tdi, irShiftQ[IR_W-1:1]};
  end

  // active instruction changes on the falling edge only
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)               irActiveQ <= INS_IDCODE;
    else if (strobe.inReset)  irActiveQ <= INS_IDCODE;
    else if (strobe.updateIr) irActiveQ <= irShiftQ;
  end

  always_comb begin
    unique case (irActiveQ)
      INS_EXTEST: instrSel = SEL_EXTEST;
      INS_SAMPLE: instrSel = SEL_SAMPLE;
      INS_IDCODE: instrSel = SEL_IDCODE;
      default:    instrSel = SEL_BYPASS;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                                            idShiftQ <= '0;
    else if (strobe.captureDr && instrSel == SEL_IDCODE)   idShiftQ <= ID_VALUE;
    else if (strobe.shiftDr && instrSel == SEL_IDCODE)     idShiftQ <= {tdi, idShiftQ[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                bypassQ <= 1'b0;
    else if (strobe.captureDr) bypassQ <= 1'b0;
    else if (strobe.shiftDr)   bypassQ <= tdi;
  end

  always_comb begin
    unique case (instrSel)
      SEL_IDCODE: drOut = idShiftQ[0];
      SEL_BYPASS: drOut = bypassQ;
      default:    drOut = bsrSerialIn;
    endcase
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strobe.shiftDr | strobe.shiftIr;
      if (strobe.shiftDr)      tdo <= drOut;
      else if (strobe.shiftIr) tdo <= irShiftQ[0];
    end
  end

  assign irActive = irActiveQ;
  assign irShift  = irShiftQ;

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'hA5C3,
  parameter logic [10:0] ID_MANUF   = 11'h2B9
)
(
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  input  logic bsrSerialIn,
  output logic tdo,
  output logic tdoEn,
  output logic dataCapture,
  output logic dataShift,
  output logic dataUpdate,
  output logic selExtest,
  output logic selSamplePreload,
  output logic selIdcode,
  output logic selBypass
);

  localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MANUF, 1'b1};

  tapState_e       ctrlState;
  tapStrobe_t      strobe;
  instrSel_e       instrSel;
  logic [IR_W-1:0] irActive;
  logic [IR_W-1:0] irShift;

  scan_tap_ctrl i_ctrl (
    .tck    (tck),
    .trstN  (trstN),
    .tms    (tms),
    .stateQ (ctrlState),
    .strobe (strobe)
  );

  scan_tap_dp #(.ID_VALUE(ID_VALUE)) i_dp (
    .tck         (tck),
    .trstN       (trstN),
    .tdi         (tdi),
    .bsrSerialIn (bsrSerialIn),
    .strobe      (strobe),
    .tdo         (tdo),
    .tdoEn       (tdoEn),
    .instrSel    (instrSel),
    .irActive    (irActive),
    .irShift     (irShift)
  );

  assign dataCapture      = strobe.captureDr;
  assign dataShift        = strobe.shiftDr;
  assign dataUpdate       = strobe.updateDr;
  assign selExtest        = (instrSel == SEL_EXTEST);
  assign selSamplePreload = (instrSel == SEL_SAMPLE);
  assign selIdcode        = (instrSel == SEL_IDCODE);
  assign selBypass        = (instrSel == SEL_BYPASS);

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic            tck,
  input logic            trstN,
  input logic            tms,
  input logic            tdoEn,
  input logic            selExtest,
  input logic            selSamplePreload,
  input logic            selIdcode,
  input logic            selBypass,
  input tapState_e       ctrlState,
  input logic [IR_W-1:0] irActive,
  input logic [IR_W-1:0] irShift
);

  // R3
  tdo_enable_chk: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (ctrlState == TAP_SH_DR || ctrlState == TAP_SH_IR));

  // R2
  tms_reset_chk: assert property (@(posedge tck) disable iff (!trstN)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (ctrlState == TAP_RESET));

  // R2
  reset_idcode_chk: assert property (@(posedge tck) disable iff (!trstN)
    (ctrlState == TAP_RESET) |-> selIdcode);

  // R9
  ir_update_only_chk: assert property (@(posedge tck) disable iff (!trstN)
    (irActive != $past(irActive)) |-> (ctrlState == TAP_UPD_IR || ctrlState == TAP_RESET));

  // R4
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trstN)
    (ctrlState == TAP_CAP_IR) |=> (irShift == IR_CAPTURE_VAL));

  // R7
  sel_onehot_chk: assert property (@(posedge tck) disable iff (!trstN)
    $countones({selExtest, selSamplePreload, selIdcode, selBypass}) == 1);

endmodule

bind scan_tap scan_tap_chk i_chk (
  .tck              (tck),
  .trstN            (trstN),
  .tms              (tms),
  .tdoEn            (tdoEn),
  .selExtest        (selExtest),
  .selSamplePreload (selSamplePreload),
  .selIdcode        (selIdcode),
  .selBypass        (selBypass),
  .ctrlState        (ctrlState),
  .irActive         (irActive),
  .irShift          (irShift)
);

// File: tb/test_scan_tap.sv
`timescale 1ns/1ps
module test_scan_tap;

  logic tck = 1'b0;
  logic trstN, tms, tdi, bsrSerialIn;
  logic tdo, tdoEn, dataCapture, dataShift, dataUpdate;
  logic selExtest, selSamplePreload, selIdcode, selBypass;

  int checks = 0;
  int errors = 0;
  logic sampTdo;

  localparam logic [31:0] ID_EXP = {4'h1, 16'hA5C3, 11'h2B9, 1'b1};

  always #2 tck = ~tck;

  scan_tap i_scan_tap (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .bsrSerialIn(bsrSerialIn),
    .tdo(tdo), .tdoEn(tdoEn), .dataCapture(dataCapture), .dataShift(dataShift),
    .dataUpdate(dataUpdate), .selExtest(selExtest), .selSamplePreload(selSamplePreload),
    .selIdcode(selIdcode), .selBypass(selBypass)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called just after a falling edge; the chain input is the inverse of tdi
  task automatic tick(input logic tmsV, input logic tdiV);
    sampTdo = tdo;
    tms = tmsV;
    tdi = tdiV;
    bsrSerialIn = ~tdiV;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic goIdle();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic loadIr(input logic [3:0] code, output logic [3:0] capBits);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, code[i]);
      capBits[i] = sampTdo;
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic scanDr(input int n, input logic [63:0] inBits, output logic [63:0] outBits);
    outBits = '0;
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, inBits[i]);
      outBits[i] = sampTdo;
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  function automatic logic [11:0] statePath(input int s);
    // {length, bits applied from MSB of the used field} starting from Run-Test/Idle
    case (s)
      0:  return {4'd3, 8'b00000111};
      1:  return {4'd1, 8'b00000000};
      2:  return {4'd1, 8'b00000001};
      3:  return {4'd2, 8'b00000010};
      4:  return {4'd3, 8'b00000100};
      5:  return {4'd3, 8'b00000101};
      6:  return {4'd4, 8'b00001010};
      7:  return {4'd5, 8'b00010101};
      8:  return {4'd4, 8'b00001011};
      9:  return {4'd2, 8'b00000011};
      10: return {4'd3, 8'b00000110};
      11: return {4'd4, 8'b00001100};
      12: return {4'd4, 8'b00001101};
      13: return {4'd5, 8'b00011010};
      14: return {4'd6, 8'b00110101};
      default: return {4'd5, 8'b00011011};
    endcase
  endfunction

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0]  cap;
    logic [63:0] outBits;
    logic [63:0] exp;
    trstN = 1'b0; tms = 1'b1; tdi = 1'b0; bsrSerialIn = 1'b0;
    repeat (3) @(negedge tck);
    #1;
    // R12 reset state
    chk(tdoEn == 1'b0, "R12 tdoEn in reset", tdoEn, 0);
    chk({selExtest, selSamplePreload, selIdcode, selBypass} == 4'b0010, "R12 selects in reset",
        {selExtest, selSamplePreload, selIdcode, selBypass}, 4'b0010);
    chk({dataCapture, dataShift, dataUpdate} == 3'b000, "R10 strobes in reset",
        {dataCapture, dataShift, dataUpdate}, 0);
    trstN = 1'b1;
    goIdle();

    // R5 identification register contents
    scanDr(32, 64'h0, outBits);
    chk(outBits[31:0] == ID_EXP, "R5 idcode scan", outBits[31:0], ID_EXP);
    chk(outBits[0] == 1'b1, "R5 idcode lsb", outBits[0], 1);

    // R7 R4 R6 R8: sweep every instruction code
    for (int c = 0; c < 16; c++) begin
      logic [3:0] expSel;
      logic [7:0] pat;
      loadIr(c[3:0], cap);
      chk(cap == 4'b0001, "R4 ir capture", cap, 4'b0001);
      expSel = (c == 0) ? 4'b1000 : (c == 1) ? 4'b0100 : (c == 2) ? 4'b0010 : 4'b0001;
      chk({selExtest, selSamplePreload, selIdcode, selBypass} == expSel, "R7 decode",
          {selExtest, selSamplePreload, selIdcode, selBypass}, expSel);
      pat = 8'h5A ^ c[7:0];
      scanDr(8, {56'h0, pat}, outBits);
      if (c == 2)           exp = {56'h0, ID_EXP[7:0]};
      else if (c <= 1)      exp = {56'h0, ~pat[6:0], 1'b1};
      else                  exp = {56'h0, pat[6:0], 1'b0};
      if (c <= 1)      chk(outBits == exp, "R8 chain path", outBits, exp);
      else if (c == 2) chk(outBits == exp, "R5 idcode path", outBits, exp);
      else             chk(outBits == exp, "R6 R7 bypass path", outBits, exp);
    end

    // R9 instruction active only after Update-IR
    goIdle();
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) tick(i == 3, 1'b1);
    chk(selIdcode == 1'b1, "R9 exit1-ir keeps old", selIdcode, 1);
    tick(1'b0, 1'b0);
    chk(selIdcode == 1'b1, "R9 pause-ir keeps old", selIdcode, 1);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    chk(selBypass == 1'b1, "R9 update-ir applies", selBypass, 1);
    tick(1'b0, 1'b0);

    // R11 tdo launched on falling edge only
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    tms = 1'b0; tdi = 1'b1;
    @(posedge tck); #0.5;
    chk(tdo == 1'b0, "R11 tdo held at rising edge", tdo, 0);
    @(negedge tck); #1;
    chk(tdo == 1'b1, "R11 tdo after falling edge", tdo, 1);

    // R12 asynchronous reset in the middle of a shift
    #0.5;
    trstN = 1'b0;
    #0.2;
    chk(tdoEn == 1'b0, "R12 async tdoEn", tdoEn, 0);
    chk(selIdcode == 1'b1, "R12 async idcode", selIdcode, 1);
    @(negedge tck); #1;
    trstN = 1'b1;
    goIdle();

    // R1 R2 R3 R10: sweep all sixteen controller states
    for (int s = 0; s < 16; s++) begin
      logic [11:0] p;
      int len;
      loadIr(4'b1111, cap);
      p = statePath(s);
      len = p[11:8];
      if (s == 1) tick(1'b0, 1'b0);
      else for (int k = len - 1; k >= 0; k--) tick(p[k], 1'b0);
      chk(tdoEn == (s == 4 || s == 11), "R3 tdoEn per state", tdoEn, (s == 4 || s == 11));
      chk({dataCapture, dataShift, dataUpdate} == {s == 3, s == 4, s == 8}, "R10 R1 strobes per state",
          {dataCapture, dataShift, dataUpdate}, {s == 3, s == 4, s == 8});
      if (s != 0 && s != 15)
        chk(selBypass == 1'b1, "R1 bypass kept on path", selBypass, 1);
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
      chk(selIdcode == 1'b1, "R2 five tms high resets", selIdcode, 1);
      chk(tdoEn == 1'b0, "R2 R3 disabled in reset", tdoEn, 0);
      tick(1'b0, 1'b0);
    end

    scanDr(32, 64'h0, outBits);
    chk(outBits[31:0] == ID_EXP, "R2 idcode after reset", outBits[31:0], ID_EXP);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule